// File: doc/BRIEF.md
# Dual Count-to-Limit Interval Timer

This block holds two identical 32-bit interval timers. A processor core reaches them through a small register bus made of an address, a write strobe with write data, and a read strobe with read data. Each timer has three registers: a running count, a limit, and a two-bit control word. The count steps up by one on every core clock. When it equals the limit, it goes back to zero on the next step. It can also raise a sticky interrupt level, one output per timer.

Software starts a timer by writing the limit, then the control word, then the starting count. To get a free-running 32-bit clock, it sets the limit to all ones and the count to zero. Any write to a timer's control word clears that timer's interrupt. The bit-0 value in the same write chooses the next mode: a one re-arms the timer for periodic events, and a zero leaves it disarmed for one-shot use. A control bit can also freeze the count while the core reports that it is halted.

Top module: `aux_interval_timer`

## Requirements
- R1: After synchronous reset, every count, limit and control register is zero, both interrupt outputs are low, and reads of all six registers return 0.
- R2: Timer 0 decodes count at 0x21, control at 0x22 and limit at 0x23. Timer 1 decodes count at 0x100, control at 0x101 and limit at 0x102. A written value reads back at its address. A control read returns the interrupt-enable bit in bit 0 and the halt-gate bit in bit 1, with all other bits zero.
- R3: A read of an address that no timer decodes returns 0.
- R4: A timer whose count is below its limit, and which is allowed to advance, increments its count by exactly one on each clock, starting from the last value written to the count.
- R5: When the count equals the limit on an advancing clock, the count is 0 on the following cycle and counting continues from there.
- R6: With the limit at 0xFFFFFFFF, the count passes from 0xFFFFFFFE to 0xFFFFFFFF and then to 0, so the timer runs free over the full 32-bit range.
- R7: The interrupt output rises on the clock where the count goes back to zero, but only if control bit 0 (interrupt enable) is 1. With bit 0 at 0, a wrap leaves the interrupt low.
- R8: The interrupt stays high until the next write to that timer's control register. Every such write clears it, whatever the data. After a write with bit 0 = 1, the next wrap raises it again.
- R9: A count write in the same cycle as an increment or a wrap wins: the count takes the written value.
- R10: With control bit 1 (halt gate) at 1 and the halted input high, the count holds. With the halt gate at 0, the halted input has no effect on counting.
- R11: The two timers are independent: register writes and interrupts of one leave the other's registers and interrupt unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Core clock; both timers step on it |
| rst_n | input | 1 | Synchronous active-low reset |
| core_halted | input | 1 | High while the core is halted |
| bus_addr | input | 12 | Register address |
| bus_wr | input | 1 | Write strobe for the addressed register |
| bus_wdata | input | 32 | Write data |
| bus_rd | input | 1 | Read strobe |
| bus_rdata | output | 32 | Read data, valid in the strobe cycle; 0 when idle or unmapped |
| timer_irq | output | 2 | Sticky interrupt level, bit i for timer i |

## Verification
The assertions check the following on every cycle:
- the single-step increment below the limit;
- the return to zero at the limit;
- the freeze under the halt gate;
- the clearing of the interrupt by a control write;
- that the interrupt only rises after a wrap with the enable set;
- the zero returned for unmapped reads.

Some behaviours depend on a software sequence and only the bench scenarios show them:
- the address map and control read format;
- the priority of a count write over a wrap;
- the full-range wrap at all ones;
- periodic re-arm against one-shot disarm;
- the independence of the two timers.

// File: rtl/tmr_pkg.sv
// Package: shared types and register offsets for the interval timer block.
// Assumes each timer occupies three consecutive addresses from its base.
package tmr_pkg;

    // Offsets of the three registers from a timer's base address
    localparam int unsigned OFS_COUNT = 0;
    localparam int unsigned OFS_CTRL  = 1;
    localparam int unsigned OFS_LIMIT = 2;

    // Stored control word: bit 1 halt gate, bit 0 interrupt enable
    typedef struct packed {
        logic halt_gate;
        logic irq_en;
    } tmr_ctrl_t;

    localparam int unsigned CTRL_W = $bits(tmr_ctrl_t);

    // One-hot register select produced by the address decoder
    typedef struct packed {
        logic limit;
        logic ctrl;
        logic count;
    } tmr_sel_t;

endpackage

// File: rtl/tmr_addr_decode.sv
// Module: tmr_addr_decode
// Compares the bus address with one timer's three register addresses and
// produces a one-hot select plus a hit flag. Assumes BASE+2 fits in AW bits.
module tmr_addr_decode
    import tmr_pkg::*;
#(
    parameter int unsigned AW   = 12,
    parameter logic [AW-1:0] BASE = '0
) (
    input  logic [AW-1:0] addr,
    output tmr_sel_t      sel,
    output logic          hit
);

    localparam logic [AW-1:0] A_COUNT = BASE + AW'(OFS_COUNT);
    localparam logic [AW-1:0] A_CTRL  = BASE + AW'(OFS_CTRL);
    localparam logic [AW-1:0] A_LIMIT = BASE + AW'(OFS_LIMIT);

    // Match the address against each register of this timer
    always_comb begin
        sel.count = (addr == A_COUNT);
        sel.ctrl  = (addr == A_CTRL);
        sel.limit = (addr == A_LIMIT);
        hit       = sel.count | sel.ctrl | sel.limit;
    end

endmodule

// File: rtl/tmr_channel.sv
// Module: tmr_channel
// One interval timer: count, limit, control and a sticky interrupt flag.
// The count steps by one per clock, returns to zero after equalling the
// limit, and freezes when the halt gate is set and the core is halted.
// A count write overrides the step; a control write clears the interrupt.
// Assumes sel is one-hot or zero and qualified by the caller's decode.
module tmr_channel
    import tmr_pkg::*;
#(
    parameter int unsigned DW = 32
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          core_halted,
    input  logic          wr_en,
    input  logic [DW-1:0] wdata,
    input  tmr_sel_t      sel,
    output logic [DW-1:0] count_o,
    output logic [DW-1:0] limit_o,
    output tmr_ctrl_t     ctrl_o,
    output logic          irq_o
);

    localparam logic [DW-1:0] ONE = DW'(1);

    logic [DW-1:0] count_q;
    logic [DW-1:0] limit_q;
    tmr_ctrl_t     ctrl_q;
    logic          irq_q;

    logic          count_wr;
    logic          ctrl_wr;
    logic          limit_wr;
    logic          advance;
    logic          at_limit;
    logic          wrap_evt;

    // Qualify writes and work out whether the count may move this cycle
    always_comb begin
        count_wr = wr_en & sel.count;
        ctrl_wr  = wr_en & sel.ctrl;
        limit_wr = wr_en & sel.limit;
        advance  = ~(ctrl_q.halt_gate & core_halted);
        at_limit = (count_q == limit_q);
        wrap_evt = advance & at_limit & ~count_wr;
    end

    // Count register: software write first, otherwise step or wrap
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            count_q <= '0;
        end else if (count_wr) begin
            count_q <= wdata;
        end else if (advance) begin
            count_q <= at_limit ? '0 : count_q + ONE;
        end
    end

    // Limit register: loaded only by software
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            limit_q <= '0;
        end else if (limit_wr) begin
            limit_q <= wdata;
        end
    end

    // Control register: keeps the low control bits of the written word
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctrl_q <= '0;
        end else if (ctrl_wr) begin
            ctrl_q <= tmr_ctrl_t'(wdata[CTRL_W-1:0]);
        end
    end

    // Interrupt flag: cleared by any control write, set by an enabled wrap
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            irq_q <= 1'b0;
        end else if (ctrl_wr) begin
            irq_q <= 1'b0;
        end else if (wrap_evt && ctrl_q.irq_en) begin
            irq_q <= 1'b1;
        end
    end

    assign count_o = count_q;
    assign limit_o = limit_q;
    assign ctrl_o  = ctrl_q;
    assign irq_o   = irq_q;

    // R4
    count_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!count_wr && advance && count_q != limit_q) |=> count_q == $past(count_q) + ONE);

    // R5
    count_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!count_wr && advance && count_q == limit_q) |=> count_q == '0);

    // R10
    halt_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!count_wr && ctrl_q.halt_gate && core_halted) |=> $stable(count_q));

    // R8
    irq_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ctrl_wr |=> !irq_q);

    // R7
    irq_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq_q) |-> ($past(ctrl_q.irq_en) && count_q == '0));

endmodule

// File: rtl/tmr_read_mux.sv
// Module: tmr_read_mux
// Returns the selected register of whichever timer decodes the address,
// zero-extending the control word. Output is zero when not reading or when
// no select is active. Assumes timer address ranges do not overlap.
module tmr_read_mux
    import tmr_pkg::*;
#(
    parameter int unsigned DW = 32,
    parameter int unsigned N  = 2
) (
    input  logic                  rd_en,
    input  tmr_sel_t [N-1:0]      sel,
    input  logic [N-1:0][DW-1:0]  counts,
    input  logic [N-1:0][DW-1:0]  limits,
    input  tmr_ctrl_t [N-1:0]     ctrls,
    output logic [DW-1:0]         rdata
);

    // OR together the selected registers of all timers
    always_comb begin
        rdata = '0;
        if (rd_en) begin
            for (int i = 0; i < N; i++) begin
                if (sel[i].count) rdata = rdata | counts[i];
                if (sel[i].limit) rdata = rdata | limits[i];
                if (sel[i].ctrl)  rdata = rdata | {{(DW-CTRL_W){1'b0}}, ctrls[i]};
            end
        end
    end

endmodule

// File: rtl/aux_interval_timer.sv
// Module: aux_interval_timer
// Top of the dual interval timer. Decodes the register bus per timer,
// instantiates one channel per timer and multiplexes read data.
// Assumes the two base addresses give disjoint three-register windows.
module aux_interval_timer
    import tmr_pkg::*;
#(
    parameter int unsigned AW = 12,
    parameter int unsigned DW = 32,
    parameter logic [AW-1:0] T0_BASE = 12'h021,
    parameter logic [AW-1:0] T1_BASE = 12'h100
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          core_halted,
    input  logic [AW-1:0] bus_addr,
    input  logic          bus_wr,
    input  logic [DW-1:0] bus_wdata,
    input  logic          bus_rd,
    output logic [DW-1:0] bus_rdata,
    output logic [1:0]    timer_irq
);

    localparam int unsigned N_TMR = 2;
    localparam logic [N_TMR-1:0][AW-1:0] BASES = {T1_BASE, T0_BASE};

    tmr_sel_t  [N_TMR-1:0]         sel;
    logic      [N_TMR-1:0]         hit;
    logic      [N_TMR-1:0][DW-1:0] counts;
    logic      [N_TMR-1:0][DW-1:0] limits;
    tmr_ctrl_t [N_TMR-1:0]         ctrls;

    for (genvar g = 0; g < N_TMR; g++) begin : g_tmr
        tmr_addr_decode #(.AW(AW), .BASE(BASES[g])) dec_i (
            .addr (bus_addr),
            .sel  (sel[g]),
            .hit  (hit[g])
        );

        tmr_channel #(.DW(DW)) chan_i (
            .clk         (clk),
            .rst_n       (rst_n),
            .core_halted (core_halted),
            .wr_en       (bus_wr),
            .wdata       (bus_wdata),
            .sel         (sel[g]),
            .count_o     (counts[g]),
            .limit_o     (limits[g]),
            .ctrl_o      (ctrls[g]),
            .irq_o       (timer_irq[g])
        );
    end

    tmr_read_mux #(.DW(DW), .N(N_TMR)) rmux_i (
        .rd_en  (bus_rd),
        .sel    (sel),
        .counts (counts),
        .limits (limits),
        .ctrls  (ctrls),
        .rdata  (bus_rdata)
    );

    // R3
    unmapped_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_rd && hit == '0) |-> bus_rdata == '0);

endmodule

// File: tb/aux_interval_timer_tb_top.sv
// Scoreboard bench: driver tasks push expected items, a monitor pops and
// compares them at a fixed point after each falling edge.
module aux_interval_timer_tb_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        core_halted = 1'b0;
    logic [11:0] bus_addr = '0;
    logic        bus_wr = 1'b0;
    logic [31:0] bus_wdata = '0;
    logic        bus_rd = 1'b0;
    logic [31:0] bus_rdata;
    logic [1:0]  timer_irq;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    typedef struct {
        bit          is_irq;
        int          idx;
        logic [31:0] exp;
        string       tag;
    } exp_t;

    exp_t sbq[$];

    always #10 clk = ~clk;

    aux_interval_timer dut_i (
        .clk         (clk),
        .rst_n       (rst_n),
        .core_halted (core_halted),
        .bus_addr    (bus_addr),
        .bus_wr      (bus_wr),
        .bus_wdata   (bus_wdata),
        .bus_rd      (bus_rd),
        .bus_rdata   (bus_rdata),
        .timer_irq   (timer_irq)
    );

    // Each task below uses exactly one clock cycle, starting at a falling edge
    task automatic op_clear();
        bus_wr = 1'b0;
        bus_rd = 1'b0;
    endtask

    task automatic wr(input logic [11:0] a, input logic [31:0] d);
        @(negedge clk);
        op_clear();
        bus_addr = a;
        bus_wdata = d;
        bus_wr = 1'b1;
    endtask

    task automatic rd(input logic [11:0] a, input logic [31:0] e, input string tag);
        exp_t it;
        @(negedge clk);
        op_clear();
        bus_addr = a;
        bus_rd = 1'b1;
        it.is_irq = 1'b0;
        it.idx = 0;
        it.exp = e;
        it.tag = tag;
        sbq.push_back(it);
    endtask

    task automatic irq_chk(input int i, input logic e, input string tag);
        exp_t it;
        @(negedge clk);
        op_clear();
        it.is_irq = 1'b1;
        it.idx = i;
        it.exp = {31'd0, e};
        it.tag = tag;
        sbq.push_back(it);
    endtask

    task automatic idle(input int n);
        for (int k = 0; k < n; k++) begin
            @(negedge clk);
            op_clear();
        end
    endtask

    task automatic set_halt(input logic v);
        @(negedge clk);
        op_clear();
        core_halted = v;
    endtask

    // Monitor: pops one expected item per cycle and compares it
    always @(negedge clk) begin
        #2;
        if (sbq.size() > 0) begin
            exp_t it;
            logic [31:0] act;
            it = sbq.pop_front();
            act = it.is_irq ? {31'd0, timer_irq[it.idx]} : bus_rdata;
            checks++;
            if (act !== it.exp) begin
                errors++;
                $display("FAIL %s actual=%h expected=%h", it.tag, act, it.exp);
            end
        end
    end

    // Watchdog: a hung run counts as one failed check
    initial begin
        repeat (5000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1 reset state
        rd(12'h021, 32'd0, "R1 t0 count");
        rd(12'h022, 32'd0, "R1 t0 ctrl");
        rd(12'h023, 32'd0, "R1 t0 limit");
        rd(12'h100, 32'd0, "R1 t1 count");
        rd(12'h101, 32'd0, "R1 t1 ctrl");
        rd(12'h102, 32'd0, "R1 t1 limit");
        irq_chk(0, 1'b0, "R1 irq0");
        irq_chk(1, 1'b0, "R1 irq1");

        // R3 unmapped reads
        rd(12'h024, 32'd0, "R3 addr 0x24");
        rd(12'h000, 32'd0, "R3 addr 0x0");
        rd(12'h103, 32'd0, "R3 addr 0x103");

        // R4 increment from written value, R2 readback
        wr(12'h023, 32'd1000);
        wr(12'h022, 32'd0);
        wr(12'h021, 32'd100);
        rd(12'h021, 32'd100, "R4 first count");
        idle(3);
        rd(12'h021, 32'd104, "R4 count after steps");
        rd(12'h023, 32'd1000, "R2 t0 limit readback");
        rd(12'h022, 32'd0, "R2 t0 ctrl readback");

        // R5 wrap, R7 interrupt, R8 sticky / clear / re-arm / disarm
        wr(12'h023, 32'd10);
        wr(12'h022, 32'd1);
        wr(12'h021, 32'd7);
        irq_chk(0, 1'b0, "R7 irq low before limit");
        idle(2);
        rd(12'h021, 32'd10, "R5 count at limit");
        rd(12'h021, 32'd0, "R5 count wrapped");
        irq_chk(0, 1'b1, "R7 irq raised on wrap");
        idle(3);
        irq_chk(0, 1'b1, "R8 irq sticky");
        wr(12'h022, 32'd1);
        irq_chk(0, 1'b0, "R8 irq cleared by ctrl write");
        idle(3);
        irq_chk(0, 1'b1, "R8 irq after re-arm");
        wr(12'h022, 32'hFFFF_FFFC);
        idle(10);
        irq_chk(0, 1'b0, "R7 no irq when disabled");
        rd(12'h022, 32'd0, "R2 ctrl keeps only two low bits");

        // R9 count write wins over wrap
        wr(12'h023, 32'd5);
        wr(12'h022, 32'd0);
        wr(12'h021, 32'd5);
        wr(12'h021, 32'd2);
        rd(12'h021, 32'd2, "R9 write beats wrap");

        // R10 halt gate, R11 independence
        set_halt(1'b1);
        wr(12'h102, 32'd1000);
        wr(12'h101, 32'd2);
        wr(12'h100, 32'd50);
        idle(3);
        rd(12'h100, 32'd50, "R10 count held while halted");
        rd(12'h101, 32'd2, "R2 t1 ctrl readback");
        set_halt(1'b0);
        rd(12'h100, 32'd51, "R10 count resumes");
        wr(12'h101, 32'd0);
        set_halt(1'b1);
        idle(1);
        rd(12'h100, 32'd55, "R10 halt ignored with gate clear");
        set_halt(1'b0);
        rd(12'h023, 32'd5, "R11 t0 limit untouched");
        irq_chk(1, 1'b0, "R11 irq1 still low");

        // R6 full-range wrap with interrupt on timer 1
        wr(12'h102, 32'hFFFF_FFFF);
        wr(12'h101, 32'd1);
        wr(12'h100, 32'hFFFF_FFFE);
        rd(12'h100, 32'hFFFF_FFFE, "R6 count at max-1");
        rd(12'h100, 32'hFFFF_FFFF, "R6 count at max");
        rd(12'h100, 32'd0, "R6 count wrapped to zero");
        irq_chk(1, 1'b1, "R6 irq1 on full wrap");
        irq_chk(0, 1'b0, "R11 irq0 unaffected");

        idle(3);
        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule